// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block produces the bit clock for a synchronous serial master from the system clock. It divides in two stages. The first stage counts half of an even prescale value. The second stage counts that stage's ticks up to a programmable rate value. The output level toggles each time the second stage wraps, so the full bit period is `prescale × (1 + rate)` system-clock cycles. The fastest setting gives half the system clock. The slowest gives one bit per 254×256 system cycles.

Besides the clock level, the block produces two single-cycle strobes. They mark the rising and the falling transitions, so a neighbouring shifter can sample and launch data without edge-detecting the clock itself. The divider only takes its settings while it is disabled. A setting written while it runs therefore cannot shorten or stretch a half period part-way through.

Top module: `serclk_gen`

## Requirements
- R1: While reset is asserted, and directly after reset, `sclkOut`, `riseStb` and `fallStb` are all 0.
- R2: While `enable` is 0, `sclkOut` is 0. If `enable` is sampled 0 while the clock is high, `sclkOut` is 0 after that same system-clock edge.
- R3: While enabled, every half period of `sclkOut` lasts exactly `(P/2) × (1 + rateSel)` system-clock cycles, where P is the effective prescale value.
- R4: The least significant bit of `preSel` is ignored, so an odd value behaves as the even value one below it. For example, 7 behaves as 6.
- R5: A `preSel` value of 0 or 1 is treated as 2. With a rate of 0, this gives a bit clock of half the system clock.
- R6: `riseStb` is 1 for exactly the one cycle in which `sclkOut` has just gone from 0 to 1, and 0 in every other cycle.
- R7: `fallStb` is 1 for exactly the one cycle in which `sclkOut` has just gone from 1 to 0, including a fall caused by disabling, and 0 in every other cycle.
- R8: Changes to `preSel` and `rateSel` made while enabled have no effect on the running clock. They are taken on the first edge at which `enable` is sampled 0.
- R9: After `enable` is first sampled 1, `sclkOut` goes high at the H-th sampled-enabled edge, where H is the half period from R3. The first rising edge therefore comes one half period after enabling.
- R10: The extreme setting of `preSel` = 254 and `rateSel` = 255 gives a half period of 32512 cycles, with no counter overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the divider. Settings are latched while this is 0 |
| preSel | input | 8 | Prescale value. Bit 0 is ignored and values below 2 act as 2 |
| rateSel | input | 8 | Second-stage rate value. The multiplier is 1 + rateSel |
| sclkOut | output | 1 | Serial bit clock level |
| riseStb | output | 1 | One-cycle strobe on a 0→1 transition of sclkOut |
| fallStb | output | 1 | One-cycle strobe on a 1→0 transition of sclkOut |

## Verification
The divider is run with several prescale and rate pairs:
- The fastest pair (2, 0) shows that back-to-back toggling works.
- A pair where only the prescale is raised (6, 0), and one where both stages are non-trivial (4, 3), show that each stage contributes its own factor.
- The odd value 7 and the sub-minimum values 0 and 1 separate correct handling of the prescale bit 0 and of the floor at 2 from a plain divide by the raw value.
- The extreme pair (254, 255) exposes any counter that is too narrow.

A reprogram-while-running pattern checks that the settings stay frozen until the divider is disabled. Disabling while the clock is high checks the forced low level and its fall strobe.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  // Control to datapath: run counts, load latches new settings.
  typedef struct packed {
    logic run;
    logic load;
  } divCtl_t;

endpackage

// File: rtl/serclk_dp.sv
module serclk_dp
  import serclk_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCtl_t           ctl,
  input  logic [PRE_W-1:0]  preIn,
  input  logic [RATE_W-1:0] rateIn,
  output logic              halfDone
);

  localparam int HALF_W = PRE_W - 1;
  localparam logic [HALF_W-1:0] HALF_ONE = HALF_W'(1);

  logic [HALF_W-1:0] cfgHalf;
  logic [RATE_W-1:0] cfgRate;
  logic [HALF_W-1:0] preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic [HALF_W-1:0] halfSel;
  logic              preTick;
  logic              runD;

  // Drop bit 0; a resulting zero means prescale below 2, clamp to half of 2.
  always_comb begin
    halfSel = preIn[PRE_W-1:1];
    if (halfSel == '0) halfSel = HALF_ONE;
  end

  assign runD     = ctl.run;
  assign preTick  = ctl.run && (preCnt == cfgHalf - HALF_ONE);
  assign halfDone = preTick && (rateCnt == cfgRate);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgHalf <= HALF_ONE;
      cfgRate <= '0;
      preCnt  <= '0;
      rateCnt <= '0;
    end else if (ctl.load) begin
      cfgHalf <= halfSel;
      cfgRate <= rateIn;
      preCnt  <= '0;
      rateCnt <= '0;
    end else if (ctl.run) begin
      preCnt <= preTick ? '0 : preCnt + HALF_ONE;
      if (preTick) rateCnt <= halfDone ? '0 : rateCnt + RATE_W'(1);
    end
  end

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(runD) |-> ($stable(cfgHalf) && $stable(cfgRate)));

  p_half_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgHalf != '0);

  p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt < cfgHalf) && (rateCnt <= cfgRate));

endmodule

// File: rtl/serclk_ctrl.sv
module serclk_ctrl
  import serclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    halfDone,
  output divCtl_t ctl,
  output logic    sclkQ,
  output logic    riseQ,
  output logic    fallQ
);

  logic nextLvl;

  always_comb begin
    ctl.run  = enable;
    ctl.load = !enable;
    nextLvl  = enable ? (sclkQ ^ halfDone) : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      sclkQ <= nextLvl;
      riseQ <= nextLvl & ~sclkQ;
      fallQ <= ~nextLvl & sclkQ;
    end
  end

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclkQ);

  p_rise_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    riseQ |-> (sclkQ && !$past(sclkQ)));

  p_rise_seen_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkQ) |-> riseQ);

  p_fall_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    fallQ |-> (!sclkQ && $past(sclkQ)));

  p_fall_seen_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkQ) |-> fallQ);

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
  import serclk_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PRE_W-1:0]  preSel,
  input  logic [RATE_W-1:0] rateSel,
  output logic              sclkOut,
  output logic              riseStb,
  output logic              fallStb
);

  divCtl_t ctl;
  logic    halfDone;

  serclk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .halfDone (halfDone),
    .ctl      (ctl),
    .sclkQ    (sclkOut),
    .riseQ    (riseStb),
    .fallQ    (fallStb)
  );

  serclk_dp #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .preIn    (preSel),
    .rateIn   (rateSel),
    .halfDone (halfDone)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (!sclkOut && !riseStb && !fallStb));

endmodule

// File: tb/sim_serclk_gen.sv
module sim_serclk_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] preSel = 8'd2;
  logic [7:0] rateSel = 8'd0;
  logic       sclkOut, riseStb, fallStb;

  int nChecks = 0;
  int nFails  = 0;
  int strobeErr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serclk_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable),
    .preSel(preSel), .rateSel(rateSel),
    .sclkOut(sclkOut), .riseStb(riseStb), .fallStb(fallStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until sclkOut changes; checks strobes on each one.
  task automatic waitChange(output int n, input int limit);
    logic prev;
    prev = sclkOut;
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (riseStb !== (sclkOut && !prev) || fallStb !== (!sclkOut && prev))
        strobeErr++;
      if (sclkOut !== prev) break;
    end
  endtask

  task automatic runCase(input int p, input int r, input int expH, input int halves,
                         input string tag);
    int n;
    enable = 1'b0;
    preSel = 8'(p);
    rateSel = 8'(r);
    strobeErr = 0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitChange(n, 2 * expH + 10);
    check(n == expH && sclkOut, {tag, " R9 first rise"}, n, expH);
    for (int i = 1; i < halves; i++) begin
      waitChange(n, 2 * expH + 10);
      check(n == expH, {tag, " R3 half period"}, n, expH);
    end
    check(strobeErr == 0, {tag, " R6 R7 strobes"}, strobeErr, 0);
    enable = 1'b0;
    @(negedge clk);
    check(sclkOut == 1'b0, {tag, " R2 low after disable"}, int'(sclkOut), 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(!sclkOut && !riseStb && !fallStb, "R1 in reset",
          int'({sclkOut, riseStb, fallStb}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!sclkOut && !riseStb && !fallStb, "R1 after reset",
          int'({sclkOut, riseStb, fallStb}), 0);
  endtask

  task automatic testDisableHigh();
    int n;
    int bad = 0;
    enable = 1'b0;
    preSel = 8'd4;
    rateSel = 8'd2;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitChange(n, 20);
    enable = 1'b0;
    @(negedge clk);
    check(!sclkOut && fallStb, "R2 R7 forced fall on disable",
          int'({sclkOut, fallStb}), 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sclkOut || riseStb || fallStb) bad++;
    end
    check(bad == 0, "R2 idle while disabled", bad, 0);
  endtask

  task automatic testHoldCfg();
    int n;
    enable = 1'b0;
    preSel = 8'd4;
    rateSel = 8'd1;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitChange(n, 20);
    preSel = 8'd20;
    rateSel = 8'd9;
    waitChange(n, 20);
    check(n == 4, "R8 new setting ignored while enabled", n, 4);
    waitChange(n, 20);
    check(n == 4, "R8 still ignored", n, 4);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitChange(n, 300);
    check(n == 100, "R8 new setting after disable", n, 100);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    testReset();
    runCase(2, 0, 1, 4, "fastest R5");
    runCase(6, 0, 3, 3, "prescale only R3");
    runCase(4, 3, 8, 3, "both stages R3");
    runCase(7, 2, 9, 3, "odd prescale R4");
    runCase(0, 3, 4, 3, "prescale zero R5");
    runCase(1, 0, 1, 3, "prescale one R5");
    testDisableHigh();
    testHoldCfg();
    runCase(254, 255, 32512, 2, "extreme R10");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule